// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Clock Generator

This block turns one slow square-wave clock, seen as an ordinary signal inside a faster system clock domain, into two phase strobes that never overlap. A divide-by-two state flips each time the slow clock falls. During each high half of the slow clock, exactly one phase is active. Which phase fires depends on the divide-by-two state, so the two phases take turns from one slow cycle to the next. Each phase therefore pulses once per two slow cycles. A consumer that needs two actions per cycle can use the slow clock at twice its own rate.

The slow clock is first brought into the system domain through a synchronizer chain. A high-to-low step of the synchronized sample advances the divide-by-two state. Both phase strobes come from registers, so they cannot glitch. A parameter sets the polarity of the main phase outputs, which are active-low by default. Active-high copies are always available. A synchronous reset clears the divide-by-two state and drives both phases inactive.

Top module: `twophase_clkgen`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, the next cycle shows `tgl_q` = 0 and both phases inactive.
- R2: With the default two synchronizer stages, a rising step on `ck_in` shows on a phase output three `clk` edges after the first edge that samples it, and not earlier.
- R3: `tgl_q` inverts once for every high-to-low step of the synchronized `ck_in`, and keeps its value otherwise.
- R4: Phase 1 is active exactly when the synchronized `ck_in` is high and the divide-by-two state is 1.
- R5: Phase 2 is active exactly when the synchronized `ck_in` is high and the divide-by-two state is 0.
- R6: Phase 1 and phase 2 are never active in the same cycle.
- R7: Each high period of the synchronized `ck_in` gives exactly one pulse. Pulses strictly alternate between the phases, and phase 2 comes first after reset.
- R8: With `ACTIVE_LOW` = 1, `phi1`/`phi2` are 0 when active and 1 when inactive. With `ACTIVE_LOW` = 0, they are 1 when active.
- R9: `phi1_pos`/`phi2_pos` are 1 exactly when the matching phase is active, whatever the value of `ACTIVE_LOW`.
- R10: `tgl_q` changes only in cycles where both phases are inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ck_in | input | 1 | Slow square-wave clock, asynchronous to `clk` |
| phi1 | output | 1 | Phase 1 strobe, polarity set by `ACTIVE_LOW` |
| phi2 | output | 1 | Phase 2 strobe, polarity set by `ACTIVE_LOW` |
| phi1_pos | output | 1 | Phase 1 strobe, always active high |
| phi2_pos | output | 1 | Phase 2 strobe, always active high |
| tgl_q | output | 1 | Divide-by-two state |

## Verification
A directed 1:1 square wave with long halves shows the basic alternation and the three-edge latency. A single rising step right after reset tells a correct synchronizer depth apart from one that is one stage short or one stage long. Random high and low lengths, including one-cycle highs and lows, check that each high period gives exactly one pulse whatever the duty ratio, and that the phase choice follows the count of falls rather than elapsed time. A reset in the middle of a high period checks that the state clears and that phase 2 leads again afterwards.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    // divide-by-two state plus the previous synchronized sample
    typedef struct packed {
        logic ck_prev;
        logic q;
    } tgl_state_t;

    // registered activity of the two phases, active high internally
    typedef struct packed {
        logic ph1;
        logic ph2;
    } phase_pair_t;

    // phase selection from the clock level and the divide-by-two state
    function automatic phase_pair_t gate_phases(input logic ck_hi, input logic q);
        phase_pair_t r;
        r.ph1 = ck_hi & q;
        r.ph2 = ck_hi & ~q;
        return r;
    endfunction

endpackage

// File: rtl/tpc_sync.sv
module tpc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d    = sh_q << 1;
        sh_d[0] = async_i;
        if (rst) sh_d = '0;
    end

    always_ff @(posedge clk) begin
        sh_q <= sh_d;
    end

    assign sync_o = sh_q[LAST];
endmodule

// File: rtl/tpc_toggle.sv
module tpc_toggle
    import tpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ck_s,
    output logic q_o,
    output logic fall_o
);
    tgl_state_t st_d, st_q;
    logic       fall;

    always_comb begin
        fall       = st_q.ck_prev & ~ck_s;
        st_d       = st_q;
        st_d.ck_prev = ck_s;
        st_d.q     = st_q.q ^ fall;
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q_o    = st_q.q;
    assign fall_o = fall;
endmodule

// File: rtl/tpc_phase_out.sv
module tpc_phase_out
    import tpc_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic ck_s,
    input  logic q,
    output logic phi1,
    output logic phi2,
    output logic phi1_pos,
    output logic phi2_pos
);
    phase_pair_t act_d, act_q;

    always_comb begin
        act_d = gate_phases(ck_s, q);
        if (rst) act_d = '0;
    end

    always_ff @(posedge clk) begin
        act_q <= act_d;
    end

    generate
        if (ACTIVE_LOW) begin : g_low
            assign phi1 = ~act_q.ph1;
            assign phi2 = ~act_q.ph2;
        end else begin : g_high
            assign phi1 = act_q.ph1;
            assign phi2 = act_q.ph2;
        end
    endgenerate

    assign phi1_pos = act_q.ph1;
    assign phi2_pos = act_q.ph2;
endmodule

// File: rtl/twophase_clkgen.sv
module twophase_clkgen #(
    parameter int SYNC_STAGES = 2,
    parameter bit ACTIVE_LOW  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic ck_in,
    output logic phi1,
    output logic phi2,
    output logic phi1_pos,
    output logic phi2_pos,
    output logic tgl_q
);
    logic ck_s;
    logic q;
    logic fall_unused;

    tpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (ck_in),
        .sync_o  (ck_s)
    );

    tpc_toggle u_toggle (
        .clk    (clk),
        .rst    (rst),
        .ck_s   (ck_s),
        .q_o    (q),
        .fall_o (fall_unused)
    );

    tpc_phase_out #(.ACTIVE_LOW(ACTIVE_LOW)) u_out (
        .clk      (clk),
        .rst      (rst),
        .ck_s     (ck_s),
        .q        (q),
        .phi1     (phi1),
        .phi2     (phi2),
        .phi1_pos (phi1_pos),
        .phi2_pos (phi2_pos)
    );

    assign tgl_q = q;
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic phi1,
    input logic phi2,
    input logic phi1_pos,
    input logic phi2_pos,
    input logic tgl_q
);
    logic act1, act2;
    logic last_one_q;

    assign act1 = ACTIVE_LOW ? ~phi1 : phi1;
    assign act2 = ACTIVE_LOW ? ~phi2 : phi2;

    // remembers which phase pulsed last; reset pretends phase 1 did
    always_ff @(posedge clk) begin
        if (rst)       last_one_q <= 1'b1;
        else if (act1) last_one_q <= 1'b1;
        else if (act2) last_one_q <= 1'b0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!act1 && !act2 && !tgl_q));

    assert_ph1_needs_q_R4: assert property (@(posedge clk) disable iff (rst)
        act1 |-> tgl_q);

    assert_ph2_needs_nq_R5: assert property (@(posedge clk) disable iff (rst)
        act2 |-> !tgl_q);

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
        !(act1 && act2));

    assert_alt_ph1_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(act1) |-> !last_one_q);

    assert_alt_ph2_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(act2) |-> last_one_q);

    assert_polarity_R8: assert property (@(posedge clk) disable iff (rst)
        (act1 == phi1_pos) && (act2 == phi2_pos));

    assert_pos_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({phi1_pos, phi2_pos}));

    assert_toggle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(tgl_q) |-> (!act1 && !act2));
endmodule

bind twophase_clkgen tpc_checker #(.ACTIVE_LOW(ACTIVE_LOW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .phi1     (phi1),
    .phi2     (phi2),
    .phi1_pos (phi1_pos),
    .phi2_pos (phi2_pos),
    .tgl_q    (tgl_q)
);

// File: tb/test_twophase_clkgen.sv
module test_twophase_clkgen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ck_in = 1'b0;
    logic phi1, phi2, phi1_pos, phi2_pos, tgl_q;
    logic h_phi1, h_phi2, h_phi1_pos, h_phi2_pos, h_tgl_q;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;   // 250 MHz

    twophase_clkgen i_twophase_clkgen (
        .clk(clk), .rst(rst), .ck_in(ck_in),
        .phi1(phi1), .phi2(phi2), .phi1_pos(phi1_pos), .phi2_pos(phi2_pos),
        .tgl_q(tgl_q));

    twophase_clkgen #(.ACTIVE_LOW(1'b0)) i_twophase_clkgen_hi (
        .clk(clk), .rst(rst), .ck_in(ck_in),
        .phi1(h_phi1), .phi2(h_phi2), .phi1_pos(h_phi1_pos), .phi2_pos(h_phi2_pos),
        .tgl_q(h_tgl_q));

    // reference model: sample history and count of falls
    logic m_h0 = 0, m_h1 = 0, m_h2 = 0, m_par = 0, m_e1 = 0, m_e2 = 0;

    function automatic logic exp_phase(input logic ck_hi, input logic par, input bit first);
        return first ? (ck_hi & par) : (ck_hi & ~par);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_h0 = 0; m_h1 = 0; m_h2 = 0; m_par = 0; m_e1 = 0; m_e2 = 0;
        end else begin
            m_par = m_par ^ (m_h2 & ~m_h1);
            m_e1  = exp_phase(m_h1, m_par, 1'b1);
            m_e2  = exp_phase(m_h1, m_par, 1'b0);
            m_h2  = m_h1; m_h1 = m_h0; m_h0 = ck_in;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, sampled on the falling edge
    logic last_was_one = 1'b1;
    logic prev_a1 = 0, prev_a2 = 0, prev_q = 0;
    always @(negedge clk) begin
        if (!done) begin
            chk("R4 phi1", phi1, ~m_e1);
            chk("R5 phi2", phi2, ~m_e2);
            chk("R3 tgl_q", tgl_q, m_par);
            chk("R9 phi1_pos", phi1_pos, m_e1);
            chk("R9 phi2_pos", phi2_pos, m_e2);
            chk("R8 high polarity phi1", h_phi1, m_e1);
            chk("R8 high polarity phi2", h_phi2, m_e2);
            if (rst) begin
                last_was_one = 1'b1;
            end else begin
                chk("R6 overlap", phi1_pos & phi2_pos, 1'b0);
                if (phi1_pos && !prev_a1) chk("R7 ph1 after ph2", last_was_one, 1'b0);
                if (phi2_pos && !prev_a2) chk("R7 ph2 after ph1", last_was_one, 1'b1);
                if (tgl_q != prev_q) chk("R10 toggle while idle", phi1_pos | phi2_pos, 1'b0);
                if (phi1_pos) last_was_one = 1'b1;
                else if (phi2_pos) last_was_one = 1'b0;
            end
            prev_a1 = phi1_pos; prev_a2 = phi2_pos; prev_q = tgl_q;
        end
    end

    task automatic hold(input logic v, input int n);
        ck_in = v;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk("R1 reset phi1", phi1, 1'b1);
        chk("R1 reset phi2", phi2, 1'b1);
        chk("R1 reset tgl_q", tgl_q, 1'b0);
        rst = 1'b0;
        repeat (6) @(negedge clk);

        // R2: latency of a single rising step
        ck_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R2 too early", phi2_pos, 1'b0);
        @(negedge clk);
        chk("R2 latency", phi2_pos, 1'b1);
        chk("R7 phase2 first", phi1_pos, 1'b0);
        hold(1'b1, 5);
        hold(1'b0, 8);

        // directed 1:1 square wave
        for (int i = 0; i < 20; i++) begin
            hold(1'b1, 8);
            hold(1'b0, 8);
        end

        // one-cycle highs and lows
        for (int i = 0; i < 20; i++) begin
            hold(1'b1, 1);
            hold(1'b0, 1);
        end
        hold(1'b0, 6);

        // reset in the middle of a high period
        hold(1'b1, 5);
        rst = 1'b1;
        hold(1'b1, 3);
        chk("R1 mid reset idle", phi1_pos | phi2_pos, 1'b0);
        rst = 1'b0;
        hold(1'b1, 6);
        chk("R7 phase2 leads after reset", phi2_pos, 1'b1);
        hold(1'b0, 6);

        // random duty and period
        for (int i = 0; i < 600; i++) begin
            hold(1'b1, $urandom_range(1, 12));
            hold(1'b0, $urandom_range(1, 12));
        end
        hold(1'b0, 6);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule